// File: doc/BRIEF.md
# SPI Slave Serial Port with Select Gating and Overrun Detection

This block is the slave end of a synchronous serial link. The serial clock always comes from the remote master, and no internal rate generator is involved. The block samples that clock, the inbound data line and the select line through synchronizer flops in its own system clock domain. It finds the clock edges by comparing successive samples. On each sampled rising edge it shifts one inbound bit into a receive register. On each falling edge inside a word it advances the outbound register. The bus idles low, so the first outbound bit must already be on the line before the first rising edge.

On the parallel side, the host writes a transmit word into a holding buffer. The buffer is copied into the outbound shift register whenever no word is in progress. When the last bit of a word arrives, the host reads the completed word from a receive buffer. A ready flag tells the host a word is waiting. A sticky overrun flag records that a word was replaced before anyone read it. Words are 8 bits or 7 bits long, and are sent and received most significant bit first.

In select-gated mode, the active-low select input controls the serial side. While select is high, clock edges are ignored, any partially received word is thrown away and the outbound driver enable drops. The buffers, flags and configuration all keep their values. In ungated mode the select input has no effect.

Top module: `spi_slave_port`

## Requirements
- R1: While no word is in progress, the serial output shows bit 7 of the last written transmit word (bit 6 in 7-bit mode). After each falling serial clock edge within a word it shows the next lower bit, so the word goes out MSB first.
- R2: The serial input is sampled on rising serial clock edges. After the last bit of a word, `rxData` holds the assembled word, MSB first, and `rxReady` is 1.
- R3: With `cfgSevenBit` = 1, a word is 7 bits long. The received word appears in `rxData[6:0]` with `rxData[7]` = 0, and the transmitted bits are `txData[6:0]`.
- R4: A one-cycle `rxRead` pulse clears `rxReady`, unless a new word completes in the same cycle.
- R5: When a word completes while `rxReady` is 1 and no read occurs in the same cycle, `overrun` becomes 1. It stays 1 through reads until an `overrunClr` pulse.
- R6: With `cfgFourPin` = 1 and `steN` high, `somiEn` is 0 and serial clock edges neither shift data nor complete a word.
- R7: In select-gated mode, raising `steN` in the middle of a word discards the bits received so far. After `steN` returns low, the next full word is received correctly from its first bit.
- R8: A high `steN` leaves `rxData`, `rxReady`, `overrun` and the transmit buffer unchanged.
- R9: With `cfgFourPin` = 0, `steN` is ignored: `somiEn` stays 1 and words are received whatever level `steN` has.
- R10: After reset, `rxReady` = 0, `overrun` = 0 and `rxData` = 0.
- R11: A transmit buffer write in the middle of a word does not change the bits still to be sent in that word. The new value is sent as the next word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgFourPin | input | 1 | 1 = select-gated mode, 0 = select ignored |
| cfgSevenBit | input | 1 | 1 = 7-bit words, 0 = 8-bit words |
| sclk | input | 1 | Serial clock from the master (asynchronous) |
| simo | input | 1 | Serial data from the master |
| steN | input | 1 | Active-low select from the master |
| somiOut | output | 1 | Serial data to the master |
| somiEn | output | 1 | Output driver enable for somiOut (0 = high impedance) |
| txData | input | 8 | Transmit word |
| txWrite | input | 1 | Write strobe for txData |
| rxData | output | 8 | Last completed received word |
| rxRead | input | 1 | Read strobe; clears rxReady |
| rxReady | output | 1 | A received word is waiting |
| overrun | output | 1 | Sticky overrun error flag |
| overrunClr | input | 1 | Clears overrun |

## Verification
The hardest case to reach from the ports is a select abort that lands partway through a word, followed by a clean word. The stale bits must not leak into that word, and the flags and the transmit word must survive the abort. Directed sequences drive select high after a few bits, toggle the serial clock while deselected, then send a full word. They compare the received data, the flags and every outbound bit. Random sequences of word lengths, data and read/clear decisions exercise the ready and overrun interaction against a bench model.

// File: rtl/spi_slv_pkg.sv
package spi_slv_pkg;
  typedef struct packed {
    logic active;    // serial side enabled
    logic loadTx;    // copy transmit buffer into shift register
    logic shiftTx;   // advance outbound bit
    logic sampleRx;  // capture inbound bit
    logic commitRx;  // last bit of word captured
  } slvStrobe_t;
endpackage

// File: rtl/spi_slv_ctrl.sv
module spi_slv_ctrl
  import spi_slv_pkg::*;
#(
  parameter int WORD_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgFourPin,
  input  logic       cfgSevenBit,
  input  logic       sclk,
  input  logic       simo,
  input  logic       steN,
  output logic       simoBit,
  output slvStrobe_t strb
);
  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] FULL_IDX  = CNT_W'(WORD_W - 1);
  localparam logic [CNT_W-1:0] SHORT_IDX = CNT_W'(WORD_W - 2);

  logic [SYNC_STAGES-1:0] sclkSync, simoSync, steSync;
  logic sclkPrev;
  logic [CNT_W-1:0] bitCnt;
  logic [CNT_W-1:0] lastIdx;
  logic sclkS, steS, active, rise, fall;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkSync <= '0;
      simoSync <= '0;
      steSync  <= '1;
      sclkPrev <= 1'b0;
    end else begin
      sclkSync <= {sclkSync[SYNC_STAGES-2:0], sclk};
      simoSync <= {simoSync[SYNC_STAGES-2:0], simo};
      steSync  <= {steSync[SYNC_STAGES-2:0], steN};
      sclkPrev <= sclkSync[SYNC_STAGES-1];
    end
  end

  assign sclkS   = sclkSync[SYNC_STAGES-1];
  assign steS    = steSync[SYNC_STAGES-1];
  assign simoBit = simoSync[SYNC_STAGES-1];
  assign active  = !cfgFourPin || !steS;
  assign rise    = active && sclkS && !sclkPrev;
  assign fall    = active && !sclkS && sclkPrev;
  assign lastIdx = cfgSevenBit ? SHORT_IDX : FULL_IDX;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0;
    end else if (!active) begin
      bitCnt <= '0;
    end else if (rise) begin
      bitCnt <= (bitCnt >= lastIdx) ? '0 : bitCnt + 1'b1;
    end
  end

  always_comb begin
    strb.active   = active;
    strb.loadTx   = (bitCnt == '0);
    strb.shiftTx  = fall && (bitCnt != '0);
    strb.sampleRx = rise;
    strb.commitRx = rise && (bitCnt >= lastIdx);
  end
endmodule

// File: rtl/spi_slv_dpath.sv
module spi_slv_dpath
  import spi_slv_pkg::*;
#(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  slvStrobe_t        strb,
  input  logic              simoBit,
  input  logic              cfgSevenBit,
  input  logic [WORD_W-1:0] txData,
  input  logic              txWrite,
  input  logic              rxRead,
  input  logic              overrunClr,
  output logic              somiOut,
  output logic              somiEn,
  output logic [WORD_W-1:0] rxData,
  output logic              rxReady,
  output logic              overrun
);
  logic [WORD_W-1:0] txBuf, txShift, rxShift, rxWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txBuf   <= '0;
      txShift <= '0;
      rxShift <= '0;
    end else begin
      if (txWrite) txBuf <= txData;
      if (strb.loadTx)       txShift <= txBuf;
      else if (strb.shiftTx) txShift <= txShift << 1;
      if (strb.sampleRx) rxShift <= {rxShift[WORD_W-2:0], simoBit};
    end
  end

  always_comb begin
    rxWord = {rxShift[WORD_W-2:0], simoBit};
    if (cfgSevenBit) rxWord[WORD_W-1] = 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxData  <= '0;
      rxReady <= 1'b0;
      overrun <= 1'b0;
    end else begin
      if (strb.commitRx) begin
        rxData  <= rxWord;
        rxReady <= 1'b1;
      end else if (rxRead) begin
        rxReady <= 1'b0;
      end
      if (strb.commitRx && rxReady && !rxRead) overrun <= 1'b1;
      else if (overrunClr)                     overrun <= 1'b0;
    end
  end

  assign somiOut = cfgSevenBit ? txShift[WORD_W-2] : txShift[WORD_W-1];
  assign somiEn  = strb.active;
endmodule

// File: rtl/spi_slave_port.sv
module spi_slave_port
  import spi_slv_pkg::*;
#(
  parameter int WORD_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgFourPin,
  input  logic              cfgSevenBit,
  input  logic              sclk,
  input  logic              simo,
  input  logic              steN,
  output logic              somiOut,
  output logic              somiEn,
  input  logic [WORD_W-1:0] txData,
  input  logic              txWrite,
  output logic [WORD_W-1:0] rxData,
  input  logic              rxRead,
  output logic              rxReady,
  output logic              overrun,
  input  logic              overrunClr
);
  slvStrobe_t strb;
  logic simoBit;

  spi_slv_ctrl #(.WORD_W(WORD_W), .SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk(clk), .rstN(rstN), .cfgFourPin(cfgFourPin), .cfgSevenBit(cfgSevenBit),
    .sclk(sclk), .simo(simo), .steN(steN), .simoBit(simoBit), .strb(strb)
  );

  spi_slv_dpath #(.WORD_W(WORD_W)) uDpath (
    .clk(clk), .rstN(rstN), .strb(strb), .simoBit(simoBit),
    .cfgSevenBit(cfgSevenBit), .txData(txData), .txWrite(txWrite),
    .rxRead(rxRead), .overrunClr(overrunClr), .somiOut(somiOut),
    .somiEn(somiEn), .rxData(rxData), .rxReady(rxReady), .overrun(overrun)
  );
endmodule

// File: rtl/spi_slave_port_chk.sv
module spi_slave_port_chk
  import spi_slv_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       cfgFourPin,
  input slvStrobe_t strb,
  input logic       somiEn,
  input logic       rxRead,
  input logic       rxReady,
  input logic       overrun,
  input logic       overrunClr
);
  // R2
  ready_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.commitRx |=> rxReady);
  // R4
  read_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxRead && !strb.commitRx) |=> !rxReady);
  // R5
  overrun_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.commitRx && rxReady && !rxRead) |=> overrun);
  // R5
  overrun_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (overrun && !overrunClr) |=> overrun);
  // R6
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.active |-> (!somiEn && !strb.sampleRx && !strb.commitRx));
  // R9
  ungated_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cfgFourPin |-> strb.active);
endmodule

bind spi_slave_port spi_slave_port_chk uChk (
  .clk(clk), .rstN(rstN), .cfgFourPin(cfgFourPin), .strb(strb),
  .somiEn(somiEn), .rxRead(rxRead), .rxReady(rxReady), .overrun(overrun),
  .overrunClr(overrunClr)
);

// File: tb/tb_spi_slave_port.sv
module tb_spi_slave_port;
  localparam int HALF = 8;
  logic clk = 0, rstN = 0;
  logic cfgFourPin = 0, cfgSevenBit = 0, sclk = 0, simo = 0, steN = 0;
  logic txWrite = 0, rxRead = 0, overrunClr = 0;
  logic [7:0] txData = 0;
  logic somiOut, somiEn, rxReady, overrun;
  logic [7:0] rxData;
  int compared = 0, mismatched = 0;
  bit done = 0;
  logic [7:0] txModel = 0, expRx = 0;
  bit expReady = 0, expOv = 0;

  always #5 clk = ~clk;

  spi_slave_port dut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic writeTx(logic [7:0] v);
    @(negedge clk); txData = v; txWrite = 1;
    @(negedge clk); txWrite = 0;
    txModel = v;
  endtask

  task automatic readRx();
    @(negedge clk); rxRead = 1;
    @(negedge clk); rxRead = 0;
    expReady = 0;
  endtask

  task automatic clrOv();
    @(negedge clk); overrunClr = 1;
    @(negedge clk); overrunClr = 0;
    expOv = 0;
  endtask

  function automatic logic [7:0] maskWord(logic [7:0] w, int nb);
    return (nb == 7) ? {1'b0, w[6:0]} : w;
  endfunction

  // drives nb bits (stops after stopAt bits when stopAt<nb); optional mid-word tx write
  task automatic xfer(logic [7:0] inW, int nb, bit checkTx, int stopAt,
                      int wrAt, logic [7:0] wrVal);
    logic [7:0] expTx = txModel;
    for (int i = nb - 1; i >= 0; i--) begin
      if (nb - 1 - i == stopAt) return;
      @(negedge clk); simo = inW[i];
      if (nb - 1 - i == wrAt) begin txData = wrVal; txWrite = 1; @(negedge clk); txWrite = 0; txModel = wrVal; end
      repeat (HALF) @(negedge clk);
      if (checkTx) chk((nb == 7) ? "R3 tx bit" : ((wrAt >= 0) ? "R11 tx bit" : "R1 tx bit"),
                       {31'd0, somiOut}, {31'd0, expTx[i]});
      sclk = 1;
      repeat (HALF) @(negedge clk);
      sclk = 0;
    end
    repeat (HALF) @(negedge clk);
  endtask

  task automatic fullWord(logic [7:0] inW, int nb, string req);
    xfer(inW, nb, 1, 99, -1, 8'h00);
    expOv = expOv | expReady;
    expReady = 1;
    expRx = maskWord(inW, nb);
    chk({req, " rxData"}, {24'd0, rxData}, {24'd0, expRx});
    chk({req, " rxReady"}, {31'd0, rxReady}, {31'd0, expReady});
    chk("R5 overrun", {31'd0, overrun}, {31'd0, expOv});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5A17));
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 rxReady", {31'd0, rxReady}, 0);
    chk("R10 overrun", {31'd0, overrun}, 0);
    chk("R10 rxData", {24'd0, rxData}, 0);
    rstN = 1;
    repeat (4) @(negedge clk);

    // R1 / R2 basic 8-bit
    writeTx(8'hA5);
    repeat (4) @(negedge clk);
    fullWord(8'h3C, 8, "R2");
    readRx();
    chk("R4 rxReady after read", {31'd0, rxReady}, 0);

    // R3 seven-bit
    cfgSevenBit = 1;
    writeTx(8'hD3);
    repeat (4) @(negedge clk);
    fullWord(8'hFF, 7, "R3");
    readRx();
    cfgSevenBit = 0;

    // R5 overrun, not cleared by read
    fullWord(8'h11, 8, "R5");
    fullWord(8'h22, 8, "R5");
    readRx();
    chk("R5 overrun sticky over read", {31'd0, overrun}, 1);
    clrOv();
    chk("R5 overrun cleared", {31'd0, overrun}, 0);

    // R11 mid-word tx write
    writeTx(8'h81);
    repeat (4) @(negedge clk);
    xfer(8'h5A, 8, 1, 99, 4, 8'h6E);
    expReady = 1; expRx = 8'h5A;
    chk("R11 rxData", {24'd0, rxData}, 8'h5A);
    readRx();
    fullWord(8'h00, 8, "R11 next word");
    readRx();

    // R9 three-pin ignores select
    steN = 1;
    repeat (4) @(negedge clk);
    chk("R9 somiEn", {31'd0, somiEn}, 1);
    fullWord(8'hC7, 8, "R9");
    steN = 0;
    fullWord(8'h99, 8, "R9");   // leave ready set for R8

    // R6 / R7 / R8 gated mode abort
    cfgFourPin = 1;
    writeTx(8'hB4);
    repeat (4) @(negedge clk);
    xfer(8'hF0, 8, 1, 3, -1, 8'h00);   // 3 bits then abort
    @(negedge clk); steN = 1;
    repeat (4) @(negedge clk);
    chk("R6 somiEn", {31'd0, somiEn}, 0);
    xfer(8'hFF, 8, 0, 99, -1, 8'h00);  // edges while deselected
    chk("R6 no completion rxData", {24'd0, rxData}, 8'h99);
    chk("R8 rxReady kept", {31'd0, rxReady}, 1);
    chk("R8 overrun kept", {31'd0, overrun}, 1);
    @(negedge clk); steN = 0;
    repeat (4) @(negedge clk);
    chk("R6 somiEn back", {31'd0, somiEn}, 1);
    readRx(); clrOv();
    fullWord(8'h6B, 8, "R7");          // tx bits check R8 buffer kept
    readRx();

    // random mix
    for (int n = 0; n < 40; n++) begin
      int nb;
      logic [7:0] w;
      cfgSevenBit = $urandom_range(0, 1);
      nb = cfgSevenBit ? 7 : 8;
      if ($urandom_range(0, 1)) begin writeTx(8'($urandom)); repeat (3) @(negedge clk); end
      w = 8'($urandom);
      fullWord(w, nb, "R2 random");
      if ($urandom_range(0, 1)) begin
        readRx();
        chk("R4 random read", {31'd0, rxReady}, 0);
      end
      if ($urandom_range(0, 3) == 0) clrOv();
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule